// File: doc/BRIEF.md
# Sideband Message Mailbox Controller

This block lets a host send one sideband message at a time to an on-chip endpoint. The host reaches it through a configuration-style register bus. Each access selects one dword and uses per-byte lane enables, so byte, word and dword accesses all work. The host stages a destination, a payload, routing fields and an extended address. It then writes the status word with the busy bit set. The controller presents the message on a valid/ready request port and keeps busy high until the message is finished. On completion it stores the endpoint's status code and response payload.

A hide byte covers the whole window. While the hide byte is nonzero, every read returns all ones. The host treats an all-ones value as an access failure. The normal flow is as follows: poll busy until it is clear, stage the fields, launch the message, then poll busy again and read back the status code and data.

Top module: `sbmb_ctrl`

## Requirements
- R1: After reset, every register reads zero, busy (status bit 0) reads 0 and `sb_req_valid` is low.
- R2: The register map uses byte addresses, and the port `cfg_addr` carries the byte address shifted right by two. The map is as follows:
  - 0xD0: bits 31:24 hold the destination port and bits 15:0 hold the register offset.
  - 0xD4: the data register.
  - 0xD8: bits 15:0 form the status word. It holds the opcode in 15:8, the posted flag in bit 7, the status code in 2:1 and busy in bit 0. Bits 31:16 form the routing word. It holds the lane mask in 31:28, the BAR selector in 26:24 and the function id in 23:16.
  - 0xDC: the extended address.
  - Only the byte lanes enabled in `cfg_be` are written. Every bit not named above reads zero.
- R3: A write to 0xD8 launches a message when byte lane 0 is enabled, bit 0 is 1, busy is 0 and the window is visible. From the next cycle, busy reads 1 and `sb_req_valid` is high with the staged fields on the request outputs. Valid stays high until `sb_req_ready` is sampled high.
- R4: When a non-posted message is accepted, busy stays 1 until `sb_rsp_valid`. The response status goes into status bits 2:1 and the response payload replaces the data register. Busy clears on that same edge.
- R5: When a posted message is accepted, busy clears on that edge. The data register keeps its value, and a response arriving while idle changes nothing.
- R6: A status-word write while busy is 1 is ignored. It does not start a second message and does not change the status fields.
- R7: Writes to the staging registers (0xD0, 0xD4, 0xD8, 0xDC) while busy is 1 are dropped. The request outputs stay stable while a message waits for acceptance.
- R8: The hide byte is at byte address 0xE1 (bits 15:8 of the dword at 0xE0) and stays writable at all times. While it is nonzero:
  - every read returns 0xFFFFFFFF;
  - writes to the staging registers are ignored;
  - no message can be launched.
- R9: Addresses outside the map read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Dword index (byte address >> 2) |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Endpoint accepts the request |
| sb_req_port | output | 8 | Destination port |
| sb_req_offset | output | 16 | Register offset |
| sb_req_opcode | output | 8 | Message opcode |
| sb_req_posted | output | 1 | Posted message, no response awaited |
| sb_req_be | output | 4 | Lane mask for the endpoint |
| sb_req_bar | output | 3 | BAR selector |
| sb_req_fid | output | 8 | Function id |
| sb_req_eaddr | output | 32 | Extended address |
| sb_req_data | output | 32 | Request payload |
| sb_rsp_valid | input | 1 | Response valid |
| sb_rsp_status | input | 2 | Response status code |
| sb_rsp_data | input | 32 | Response payload |

## Verification
The checker watches the following on every cycle:
- the request handshake: valid is held and its fields stay stable until ready;
- busy after acceptance: a posted message frees busy, and a non-posted message keeps it;
- that no request appears while idle;
- that a hidden window reads all ones.

The bench's scenarios are needed for the rest:
- byte-lane merging and reserved-bit zeroing;
- which writes are dropped while busy or hidden;
- where the response status and payload are stored;
- that an ignored second launch produces no later message.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;

  // dword indices (byte address >> 2) of the register window
  localparam logic [5:0] IDX_ADDR = 6'h34;
  localparam logic [5:0] IDX_DATA = 6'h35;
  localparam logic [5:0] IDX_STRT = 6'h36;
  localparam logic [5:0] IDX_EXT  = 6'h37;
  localparam logic [5:0] IDX_HIDE = 6'h38;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;

  typedef struct packed {
    logic [7:0]  port;
    logic [15:0] offset;
    logic [7:0]  opcode;
    logic        posted;
    logic [3:0]  lane_mask;
    logic [2:0]  bar;
    logic [7:0]  fid;
    logic [31:0] eaddr;
    logic [31:0] data;
  } sb_req_t;

  function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                             input logic [31:0] upd,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[i*8 +: 8] = be[i] ? upd[i*8 +: 8] : cur[i*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/sbmb_rst_sync.sv
module sbmb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/sbmb_seq.sv
module sbmb_seq
  import sbmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic posted,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic busy,
  output logic rsp_load
);
  sq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (launch)    st_d = SQ_REQ;
      SQ_REQ:  if (req_ready) st_d = posted ? SQ_IDLE : SQ_WAIT;
      SQ_WAIT: if (rsp_valid) st_d = SQ_IDLE;
      default:                st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign req_valid = (st_q == SQ_REQ);
  assign busy      = (st_q != SQ_IDLE);
  assign rsp_load  = (st_q == SQ_WAIT) && rsp_valid;
endmodule

// File: rtl/sbmb_regs.sv
module sbmb_regs
  import sbmb_pkg::*;
#(
  parameter int unsigned CFG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] idx,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              busy,
  input  logic              rsp_load,
  input  logic [1:0]        rsp_status,
  input  logic [31:0]       rsp_data,
  output logic [31:0]       rd_data,
  output logic              hide_on,
  output logic              launch,
  output sb_req_t           stage
);
  localparam logic [CFG_AW-1:0] A_ADDR = CFG_AW'(IDX_ADDR);
  localparam logic [CFG_AW-1:0] A_DATA = CFG_AW'(IDX_DATA);
  localparam logic [CFG_AW-1:0] A_STRT = CFG_AW'(IDX_STRT);
  localparam logic [CFG_AW-1:0] A_EXT  = CFG_AW'(IDX_EXT);
  localparam logic [CFG_AW-1:0] A_HIDE = CFG_AW'(IDX_HIDE);

  logic [7:0]  port_q, port_d;
  logic [15:0] off_q, off_d;
  logic [7:0]  opc_q, opc_d;
  logic        pst_q, pst_d;
  logic [1:0]  code_q, code_d;
  logic [3:0]  lm_q, lm_d;
  logic [2:0]  bar_q, bar_d;
  logic [7:0]  fid_q, fid_d;
  logic [31:0] ext_q, ext_d;
  logic [7:0]  hide_q, hide_d;
  logic [31:0] data_q;
  logic        stage_ok;
  logic        cfg_en;

  assign stage_ok = wr_en && !busy && (hide_q == 8'h00);
  assign launch   = stage_ok && (idx == A_STRT) && wr_be[0] && wr_data[0];
  assign cfg_en   = stage_ok || rsp_load || (wr_en && (idx == A_HIDE));

  // next-state for control/address fields
  always_comb begin
    port_d = port_q; off_d = off_q; opc_d = opc_q; pst_d = pst_q;
    code_d = code_q; lm_d = lm_q; bar_d = bar_q; fid_d = fid_q;
    ext_d  = ext_q;  hide_d = hide_q;
    if (stage_ok) begin
      unique case (idx)
        A_ADDR: begin
          if (wr_be[3]) port_d       = wr_data[31:24];
          if (wr_be[1]) off_d[15:8]  = wr_data[15:8];
          if (wr_be[0]) off_d[7:0]   = wr_data[7:0];
        end
        A_STRT: begin
          if (wr_be[0]) begin
            pst_d  = wr_data[7];
            code_d = wr_data[2:1];
          end
          if (wr_be[1]) opc_d = wr_data[15:8];
          if (wr_be[2]) fid_d = wr_data[23:16];
          if (wr_be[3]) begin
            lm_d  = wr_data[31:28];
            bar_d = wr_data[26:24];
          end
        end
        A_EXT:  ext_d = lane_merge(ext_q, wr_data, wr_be);
        default: ;
      endcase
    end
    if (wr_en && (idx == A_HIDE) && wr_be[1]) hide_d = wr_data[15:8];
    if (rsp_load) code_d = rsp_status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0; off_q <= '0; opc_q <= '0; pst_q <= 1'b0;
      code_q <= '0; lm_q  <= '0; bar_q <= '0; fid_q <= '0;
      ext_q  <= '0; hide_q <= '0;
    end else if (cfg_en) begin
      port_q <= port_d; off_q <= off_d; opc_q <= opc_d; pst_q <= pst_d;
      code_q <= code_d; lm_q  <= lm_d;  bar_q <= bar_d; fid_q <= fid_d;
      ext_q  <= ext_d;  hide_q <= hide_d;
    end
  end

  // data register: one enable per byte lane, response has priority
  for (genvar g = 0; g < LANES; g++) begin : g_data_lane
    logic       ln_en;
    logic [7:0] ln_d;
    assign ln_en = rsp_load || (stage_ok && (idx == A_DATA) && wr_be[g]);
    assign ln_d  = rsp_load ? rsp_data[g*8 +: 8] : wr_data[g*8 +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data_q[g*8 +: 8] <= '0;
      else if (ln_en) data_q[g*8 +: 8] <= ln_d;
    end
  end

  always_comb begin
    unique case (idx)
      A_ADDR:  rd_data = {port_q, 8'h00, off_q};
      A_DATA:  rd_data = data_q;
      A_STRT:  rd_data = {lm_q, 1'b0, bar_q, fid_q, opc_q, pst_q, 4'h0, code_q, busy};
      A_EXT:   rd_data = ext_q;
      A_HIDE:  rd_data = {16'h0000, hide_q, 8'h00};
      default: rd_data = 32'h0000_0000;
    endcase
    if (hide_q != 8'h00) rd_data = 32'hFFFF_FFFF;
  end

  assign hide_on = (hide_q != 8'h00);

  always_comb begin
    stage.port      = port_q;
    stage.offset    = off_q;
    stage.opcode    = opc_q;
    stage.posted    = pst_q;
    stage.lane_mask = lm_q;
    stage.bar       = bar_q;
    stage.fid       = fid_q;
    stage.eaddr     = ext_q;
    stage.data      = data_q;
  end
endmodule

// File: rtl/sbmb_ctrl.sv
module sbmb_ctrl
  import sbmb_pkg::*;
#(
  parameter int unsigned CFG_AW    = 6,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              sb_req_valid,
  input  logic              sb_req_ready,
  output logic [7:0]        sb_req_port,
  output logic [15:0]       sb_req_offset,
  output logic [7:0]        sb_req_opcode,
  output logic              sb_req_posted,
  output logic [3:0]        sb_req_be,
  output logic [2:0]        sb_req_bar,
  output logic [7:0]        sb_req_fid,
  output logic [31:0]       sb_req_eaddr,
  output logic [31:0]       sb_req_data,
  input  logic              sb_rsp_valid,
  input  logic [1:0]        sb_rsp_status,
  input  logic [31:0]       sb_rsp_data
);
  logic    rst_sync_n;
  logic    busy;
  logic    launch;
  logic    rsp_load;
  logic    hide_on;
  sb_req_t stage;

  sbmb_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  sbmb_regs #(.CFG_AW(CFG_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (cfg_wr),
    .idx        (cfg_addr),
    .wr_be      (cfg_be),
    .wr_data    (cfg_wdata),
    .busy       (busy),
    .rsp_load   (rsp_load),
    .rsp_status (sb_rsp_status),
    .rsp_data   (sb_rsp_data),
    .rd_data    (cfg_rdata),
    .hide_on    (hide_on),
    .launch     (launch),
    .stage      (stage)
  );

  sbmb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (launch),
    .posted    (stage.posted),
    .req_ready (sb_req_ready),
    .rsp_valid (sb_rsp_valid),
    .req_valid (sb_req_valid),
    .busy      (busy),
    .rsp_load  (rsp_load)
  );

  assign sb_req_port   = stage.port;
  assign sb_req_offset = stage.offset;
  assign sb_req_opcode = stage.opcode;
  assign sb_req_posted = stage.posted;
  assign sb_req_be     = stage.lane_mask;
  assign sb_req_bar    = stage.bar;
  assign sb_req_fid    = stage.fid;
  assign sb_req_eaddr  = stage.eaddr;
  assign sb_req_data   = stage.data;
endmodule

// File: rtl/sbmb_chk.sv
module sbmb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        hide_on,
  input logic [31:0] cfg_rdata,
  input logic        sb_req_valid,
  input logic        sb_req_ready,
  input logic        sb_req_posted,
  input logic [7:0]  sb_req_port,
  input logic [31:0] sb_req_data,
  input logic [31:0] sb_req_eaddr
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sb_req_valid);                                           // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid && !sb_req_ready |=> sb_req_valid);                    // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid && !sb_req_ready |=> $stable(sb_req_port) && $stable(sb_req_data)
                                      && $stable(sb_req_eaddr));        // R7
  AST_NP_KEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid && sb_req_ready && !sb_req_posted |=> busy);           // R4
  AST_POSTED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid && sb_req_ready && sb_req_posted |=> !busy);           // R5
  AST_HIDE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    hide_on |-> cfg_rdata == 32'hFFFF_FFFF);                            // R8
endmodule

bind sbmb_ctrl sbmb_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .busy          (busy),
  .hide_on       (hide_on),
  .cfg_rdata     (cfg_rdata),
  .sb_req_valid  (sb_req_valid),
  .sb_req_ready  (sb_req_ready),
  .sb_req_posted (sb_req_posted),
  .sb_req_port   (sb_req_port),
  .sb_req_data   (sb_req_data),
  .sb_req_eaddr  (sb_req_eaddr)
);

// File: tb/sbmb_ctrl_tb.sv
module sbmb_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sb_req_valid, sb_req_ready = 1'b0;
  logic [7:0]  sb_req_port, sb_req_opcode, sb_req_fid;
  logic [15:0] sb_req_offset;
  logic        sb_req_posted;
  logic [3:0]  sb_req_be;
  logic [2:0]  sb_req_bar;
  logic [31:0] sb_req_eaddr, sb_req_data;
  logic        sb_rsp_valid = 1'b0;
  logic [1:0]  sb_rsp_status = '0;
  logic [31:0] sb_rsp_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbmb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sb_req_valid(sb_req_valid),
    .sb_req_ready(sb_req_ready), .sb_req_port(sb_req_port), .sb_req_offset(sb_req_offset),
    .sb_req_opcode(sb_req_opcode), .sb_req_posted(sb_req_posted), .sb_req_be(sb_req_be),
    .sb_req_bar(sb_req_bar), .sb_req_fid(sb_req_fid), .sb_req_eaddr(sb_req_eaddr),
    .sb_req_data(sb_req_data), .sb_rsp_valid(sb_rsp_valid), .sb_rsp_status(sb_rsp_status),
    .sb_rsp_data(sb_rsp_data)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // cumulative register write / readback vectors (R2, R9)
  localparam vec_t VECS [10] = '{
    '{6'h34, 4'hF, 32'hFFFF_FFFF, 32'hFF00_FFFF},
    '{6'h34, 4'h8, 32'h1234_5678, 32'h1200_FFFF},
    '{6'h34, 4'h1, 32'h0000_00AB, 32'h1200_FFAB},
    '{6'h37, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{6'h37, 4'h2, 32'h0000_5500, 32'hDEAD_55EF},
    '{6'h35, 4'hC, 32'hCAFE_0000, 32'hCAFE_0000},
    '{6'h36, 4'hC, 32'hFFFF_0000, 32'hF7FF_0000},
    '{6'h36, 4'h2, 32'h0000_A500, 32'hF7FF_A500},
    '{6'h36, 4'h1, 32'h0000_00FE, 32'hF7FF_A586},
    '{6'h39, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%h exp=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd(6'(6'h34 + i), v);
      check("R1 reset reg", v, 32'h0);
    end
    check("R1 reset valid", {31'h0, sb_req_valid}, 32'h0);

    // R2 / R9 vector table
    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].idx, VECS[i].be, VECS[i].wd);
      rd(VECS[i].idx, v);
      check((VECS[i].idx == 6'h39) ? "R9 unmapped" : "R2 map", v, VECS[i].exp);
    end

    // R3 non-posted launch, opcode 0x06
    wr(6'h36, 4'h3, 32'h0000_0601);
    check("R3 valid", {31'h0, sb_req_valid}, 32'h1);
    check("R3 port/offset", {sb_req_port, 8'h0, sb_req_offset}, 32'h1200_FFAB);
    check("R3 opc/be/bar/fid", {sb_req_opcode, sb_req_be, 1'b0, sb_req_bar, sb_req_fid, 7'h0, sb_req_posted},
          {8'h06, 4'hF, 1'b0, 3'h7, 8'hFF, 7'h0, 1'b0});
    check("R3 eaddr", sb_req_eaddr, 32'hDEAD_55EF);
    check("R3 data", sb_req_data, 32'hCAFE_0000);
    rd(6'h36, v);
    check("R3 busy status", v, 32'hF7FF_0601);
    // R7 staging write while busy dropped
    wr(6'h35, 4'hF, 32'h1111_1111);
    rd(6'h35, v);
    check("R7 data frozen", v, 32'hCAFE_0000);
    wr(6'h34, 4'hF, 32'h0000_0000);
    check("R7 port output stable", {24'h0, sb_req_port}, 32'h12);
    // R6 status write while busy ignored
    wr(6'h36, 4'h3, 32'h0000_0781);
    rd(6'h36, v);
    check("R6 status unchanged", v, 32'hF7FF_0601);
    check("R3 valid held", {31'h0, sb_req_valid}, 32'h1);
    // accept
    @(negedge clk); sb_req_ready = 1'b1;
    @(negedge clk); sb_req_ready = 1'b0; #1;
    check("R4 valid drops", {31'h0, sb_req_valid}, 32'h0);
    repeat (2) @(negedge clk);
    rd(6'h36, v);
    check("R4 busy held", {31'h0, v[0]}, 32'h1);
    @(negedge clk); sb_rsp_valid = 1'b1; sb_rsp_status = 2'b10; sb_rsp_data = 32'h55AA_1234;
    @(negedge clk); sb_rsp_valid = 1'b0; sb_rsp_data = '0; sb_rsp_status = '0;
    rd(6'h36, v);
    check("R4 status code", v, 32'hF7FF_0604);
    rd(6'h35, v);
    check("R4 payload", v, 32'h55AA_1234);
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #1;
        if (sb_req_valid) seen++;
      end
      check("R6 no second message", 32'(seen), 32'h0);
    end

    // R5 posted launch
    wr(6'h36, 4'h1, 32'h0000_0081);
    check("R5 posted flag", {31'h0, sb_req_posted}, 32'h1);
    @(negedge clk); sb_req_ready = 1'b1;
    @(negedge clk); sb_req_ready = 1'b0;
    rd(6'h36, v);
    check("R5 busy cleared", v, 32'hF7FF_0680);
    @(negedge clk); sb_rsp_valid = 1'b1; sb_rsp_status = 2'b11; sb_rsp_data = 32'h0;
    @(negedge clk); sb_rsp_valid = 1'b0; sb_rsp_status = '0;
    rd(6'h35, v);
    check("R5 data kept", v, 32'h55AA_1234);
    rd(6'h36, v);
    check("R5 stray response ignored", v, 32'hF7FF_0680);

    // R8 hide
    wr(6'h38, 4'h2, 32'h0000_0100);
    rd(6'h34, v);
    check("R8 hidden addr", v, 32'hFFFF_FFFF);
    rd(6'h38, v);
    check("R8 hidden hide", v, 32'hFFFF_FFFF);
    rd(6'h39, v);
    check("R8 hidden unmapped", v, 32'hFFFF_FFFF);
    wr(6'h34, 4'hF, 32'h0000_0000);
    wr(6'h36, 4'h1, 32'h0000_0001);
    check("R8 no launch", {31'h0, sb_req_valid}, 32'h0);
    wr(6'h38, 4'h2, 32'h0000_0000);
    rd(6'h34, v);
    check("R8 addr kept", v, 32'h1200_FFAB);
    rd(6'h36, v);
    check("R8 status kept", v, 32'hF7FF_0680);
    rd(6'h38, v);
    check("R8 unhidden", v, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule